// File: doc/BRIEF.md
# Serial Tuner Control Register

This block takes a 28-bit control word over a three-pin serial link (data, clock, enable) and holds the settings a frequency synthesizer and its band selector need: four band-select lines, a charge-pump disable, a charge-pump current select, a 4-bit reference divider code, a 13-bit main divider count and a 4-bit swallow count. All three pins are sampled by a fast system clock. Each pin passes through a two-flop synchronizer, and its edges are found in the system clock domain.

While enable is high, each falling edge of the serial clock shifts one data bit in and advances a bit counter. The counter restarts when enable rises. When enable falls, the word is copied to the holding registers only if exactly 28 bits were clocked in. Any other count discards the word and the previous settings stay in place. A one-cycle load strobe marks each update.

Top module: `serial_tuner_ctrl`

## Requirements
- R1: A data bit is shifted in only on a falling edge of the serial clock while enable is high. Serial clock activity while enable is low has no effect on the next word or on the outputs.
- R2: The first bit sent drives band_o[3], and the next three drive band_o[2], band_o[1] and band_o[0]. The fifth bit is a spare, and its value has no effect on any output.
- R3: The sixth bit drives cp_off_o. A 1 turns off both the charge pump and the tuning-voltage drive.
- R4: The seventh bit drives cp_hi_o, where 0 selects the low pump current and 1 selects the high one.
- R5: Bits 8 to 11 form ref_code_o, sent MSB first.
- R6: Bits 12 to 24 form main_cnt_o (MSB first) and bits 25 to 28 form swallow_o (MSB first), covering main counts 0 to 8191.
- R7: Outputs are updated only on the falling edge of enable, and only when exactly 28 serial clock falls occurred since enable rose. Any other count, from 0 up to and beyond 28, leaves every output unchanged.
- R8: The bit count restarts at each rising edge of enable, so a discarded partial burst does not carry into the next word.
- R9: After the asynchronous reset, every output is 0 and load_o is low.
- R10: load_o is high for exactly one system clock cycle for each accepted word, and never for a discarded word.
- R11: When an enable fall is presented at the pin, the new outputs and load_o appear after the third rising system clock edge. After the second edge they still hold their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data pin |
| sclk_i | input | 1 | Serial clock pin |
| sen_i | input | 1 | Serial enable pin |
| band_o | output | 4 | Band-select lines, 1 = active |
| cp_off_o | output | 1 | Charge pump and tuning drive off |
| cp_hi_o | output | 1 | High charge-pump current |
| ref_code_o | output | 4 | Reference divider code |
| main_cnt_o | output | 13 | Main divider count |
| swallow_o | output | 4 | Swallow counter count |
| load_o | output | 1 | One-cycle strobe on update |

## Verification
An edge at a pin reaches the shift register and counter after three system clock edges: two synchronizer stages, then the register that acts on the detected edge. The holding registers and load_o change on that same third edge after enable falls. The bench changes pins only on falling system clock edges and holds each serial clock phase for four cycles, so every pin edge is resolved before the next one arrives. Field checks are made eight cycles after enable falls. One directed test samples exactly two and three edges after the fall to pin down the R11 latency, and load_o is counted on falling edges across each whole transaction.

// File: rtl/tuner_ctrl_pkg.sv
package tuner_ctrl_pkg;
  parameter int BAND_W = 4;
  parameter int REF_W  = 4;
  parameter int MAIN_W = 13;
  parameter int SWAL_W = 4;
  localparam int CTRL_W = 3;  // spare, pump off, pump high
  localparam int WORD_W = BAND_W + CTRL_W + REF_W + MAIN_W + SWAL_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);

  // MSB is the first bit on the wire
  typedef struct packed {
    logic [BAND_W-1:0] band;
    logic              spare;
    logic              cp_off;
    logic              cp_hi;
    logic [REF_W-1:0]  ref_code;
    logic [MAIN_W-1:0] main_cnt;
    logic [SWAL_W-1:0] swallow;
  } ctrl_word_t;
endpackage

// File: rtl/tc_pin_sync.sv
module tc_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-1:0], pin_i[g]};
    end
    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o[g] = ~chain_q[STAGES-1] & chain_q[STAGES];

    a_r1_edge_follows_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> $past(lvl_o[g]) && !fall_o[g]);
  end
endmodule

// File: rtl/tc_shift_count.sv
module tc_shift_count
  import tuner_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_lvl_i,
  input  logic              en_rise_i,
  input  logic              sclk_fall_i,
  input  logic              data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take_bit;

  assign take_bit = sclk_fall_i & en_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (take_bit) sr_q <= {sr_q[WORD_W-2:0], data_i};
  end

  // saturate past the word length so long bursts never alias to a full count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (en_rise_i)                   cnt_q <= '0;
    else if (take_bit && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign word_o = sr_q;
  assign full_o = (cnt_q == CNT_FULL);

  a_r8_count_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise_i |=> cnt_q == '0);
  a_r1_idle_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_lvl_i |=> $stable(sr_q));
  a_r1_bit_enters_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_bit |=> sr_q[0] == $past(data_i));
endmodule

// File: rtl/tc_hold.sv
module tc_hold
  import tuner_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  ctrl_word_t word_i,
  output ctrl_word_t word_o,
  output logic       load_o
);
  ctrl_word_t word_q;
  logic       load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= take_i;
      if (take_i) begin
        word_q       <= word_i;
        word_q.spare <= 1'b0;
      end
    end
  end

  assign word_o = word_q;
  assign load_o = load_q;

  a_r7_change_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_q != $past(word_q)) |-> load_q);
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q);
  a_r2_spare_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_q.spare);
endmodule

// File: rtl/serial_tuner_ctrl.sv
module serial_tuner_ctrl
  import tuner_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              sen_i,
  output logic [BAND_W-1:0] band_o,
  output logic              cp_off_o,
  output logic              cp_hi_o,
  output logic [REF_W-1:0]  ref_code_o,
  output logic [MAIN_W-1:0] main_cnt_o,
  output logic [SWAL_W-1:0] swallow_o,
  output logic              load_o
);
  localparam int PIN_DATA = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_EN   = 2;

  logic [2:0]        lvl, rise, fall;
  logic [WORD_W-1:0] shift_word;
  logic              full;
  ctrl_word_t        held;
  logic              unused_edges;

  tc_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({sen_i, sclk_i, sdata_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign unused_edges = ^{rise[PIN_DATA], rise[PIN_SCLK], fall[PIN_DATA], lvl[PIN_SCLK]};

  tc_shift_count u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_lvl_i    (lvl[PIN_EN]),
    .en_rise_i   (rise[PIN_EN]),
    .sclk_fall_i (fall[PIN_SCLK]),
    .data_i      (lvl[PIN_DATA]),
    .word_o      (shift_word),
    .full_o      (full)
  );

  tc_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (fall[PIN_EN] & full),
    .word_i (ctrl_word_t'(shift_word)),
    .word_o (held),
    .load_o (load_o)
  );

  assign band_o     = held.band;
  assign cp_off_o   = held.cp_off;
  assign cp_hi_o    = held.cp_hi;
  assign ref_code_o = held.ref_code;
  assign main_cnt_o = held.main_cnt;
  assign swallow_o  = held.swallow;

  a_r7_load_on_enable_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(fall[PIN_EN]));
  a_r7_load_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(full));
endmodule

// File: tb/serial_tuner_ctrl_bench.sv
module serial_tuner_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, sen = 1'b0;
  logic [3:0]  band_o, ref_code_o, swallow_o;
  logic [12:0] main_cnt_o;
  logic        cp_off_o, cp_hi_o, load_o;

  int tests = 0, fails = 0, loads = 0;
  bit done = 1'b0;

  // expected state
  logic [3:0]  e_band = '0, e_ref = '0, e_swal = '0;
  logic [12:0] e_main = '0;
  logic        e_off = 1'b0, e_hi = 1'b0;

  always #2.5 clk = ~clk;

  serial_tuner_ctrl u_serial_tuner_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk), .sen_i(sen),
    .band_o(band_o), .cp_off_o(cp_off_o), .cp_hi_o(cp_hi_o),
    .ref_code_o(ref_code_o), .main_cnt_o(main_cnt_o), .swallow_o(swallow_o),
    .load_o(load_o)
  );

  always @(negedge clk) if (load_o) loads++;

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] exp_vec();
    return {e_band, e_off, e_hi, e_ref, e_main, e_swal};
  endfunction

  function automatic logic [26:0] act_vec();
    return {band_o, cp_off_o, cp_hi_o, ref_code_o, main_cnt_o, swallow_o};
  endfunction

  function automatic logic [27:0] pack(logic [3:0] b, logic sp, logic off, logic hi,
                                       logic [3:0] r, logic [12:0] m, logic [3:0] s);
    return {b, sp, off, hi, r, m, s};
  endfunction

  // R1: two clock pulses with enable low precede every word
  task automatic send(logic [27:0] w, int nbits, bit lat);
    loads = 0;
    for (int i = 0; i < 2; i++) begin
      sdata = 1'b1; wait_n(4); sclk = 1'b1; wait_n(4); sclk = 1'b0; wait_n(4);
    end
    sen = 1'b1; wait_n(4);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 28) ? w[27-i] : 1'b1;
      wait_n(4); sclk = 1'b1; wait_n(4); sclk = 1'b0; wait_n(4);
    end
    sen = 1'b0;
    if (nbits == 28) begin
      if (lat) begin
        wait_n(2);
        check("R11 old value two edges after enable fall", act_vec(), exp_vec());
        check("R11 strobe not yet", load_o, 0);
      end
      {e_band, e_off, e_hi, e_ref, e_main, e_swal} = {w[27:24], w[22:0]};
      if (lat) begin
        wait_n(1);
        check("R11 new value on third edge", act_vec(), exp_vec());
        check("R11 strobe on third edge", load_o, 1);
      end
    end
    wait_n(8);
  endtask

  initial begin
    wait_n(3);
    check("R9 reset outputs", act_vec(), 0);
    check("R9 reset strobe", load_o, 0);
    rst_n = 1'b1;
    wait_n(3);

    // R2 R3 R4 R5 R6 R10: sweep all band patterns with varying fields
    for (int b = 0; b < 16; b++) begin
      logic [12:0] m = 13'((b * 523 + 7) % 8192);
      send(pack(4'(b), b[3], b[0], b[1], 4'(15 - b), m, 4'(b ^ 5)), 28, 1'b0);
      check("R2 R3 R4 R5 R6 fields", act_vec(), exp_vec());
      check("R10 one strobe per word", loads, 1);
    end

    // R6: main count extremes
    send(pack(4'h8, 1'b0, 1'b0, 1'b1, 4'h3, 13'h1fff, 4'hf), 28, 1'b0);
    check("R6 main count 8191", main_cnt_o, 13'h1fff);
    send(pack(4'h1, 1'b0, 1'b1, 1'b0, 4'hc, 13'h0000, 4'h0), 28, 1'b0);
    check("R6 main count 0", main_cnt_o, 0);

    // R2: spare bit has no effect
    send(pack(4'h2, 1'b1, 1'b1, 1'b0, 4'hc, 13'h0000, 4'h0), 28, 1'b0);
    check("R2 spare bit ignored", act_vec(), exp_vec());

    // R7 R10: every wrong length is discarded
    for (int n = 0; n < 32; n++) begin
      if (n == 28) continue;
      send(pack(4'h4, 1'b0, 1'b0, 1'b1, 4'h9, 13'h0aaa, 4'h5), n, 1'b0);
      check("R7 wrong length keeps outputs", act_vec(), exp_vec());
      check("R10 no strobe on discard", loads, 0);
    end

    // R8: partial burst then a full word
    send(pack(4'h1, 1'b0, 1'b1, 1'b1, 4'h6, 13'h0123, 4'h9), 13, 1'b0);
    send(pack(4'h4, 1'b0, 1'b1, 1'b1, 4'h6, 13'h1234, 4'h9), 28, 1'b0);
    check("R8 count restarts on enable rise", act_vec(), exp_vec());

    // R11: exact latency of the update
    send(pack(4'h8, 1'b0, 1'b0, 1'b0, 4'ha, 13'h0f0f, 4'h3), 28, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule